// File: doc/BRIEF.md
# APB Requester Transfer Controller

This block is the requester side of an APB link. An upstream agent offers one transfer at a time on a valid/ready command port carrying a write flag, an address and write data. The controller turns each accepted command into an APB transfer. It spends one select-only cycle, then an enable cycle that lasts until the completer signals ready. It then returns a one-cycle done pulse, together with the read data when the transfer was a read.

The controller has three states: idle, setup and access. The select output is high in setup and access. The enable output is nothing more than the access-state decode, so it rises only when the controller moves from setup to access and falls only when the transfer completes. If a new command is waiting on the completing cycle, the controller goes straight back to setup with no idle cycle in between.

Top module: `apb_xfer_mgr`

## Requirements
- R1: While rst_ni is low, and after its release until a command is accepted, psel_o, penable_o and rsp_done_o are 0 and req_ready_o is 1.
- R2: penable_o is 1 only in the access state and is never 1 while psel_o is 0.
- R3: A command accepted on a clock edge (req_valid_i and req_ready_o both high) puts the controller in setup for exactly one cycle. In that cycle psel_o=1 and penable_o=0, and paddr_o, pwrite_o and pwdata_o show the command. The next cycle is access.
- R4: In access with pready_i=0 the controller stays in access. penable_o stays 1 and paddr_o, pwrite_o and pwdata_o stay unchanged, whatever happens on the command port.
- R5: With pready_i=1 in the first access cycle, penable_o is 1 for exactly one cycle.
- R6: When access completes (pready_i=1) and req_valid_i=0, the next cycle is idle, with psel_o=0 and penable_o=0.
- R7: When access completes and req_valid_i=1, the new command is accepted and the next cycle is setup for it: psel_o stays 1, penable_o=0 and paddr_o shows the new address.
- R8: req_ready_o is 1 in idle and on an access cycle with pready_i=1, and is 0 otherwise.
- R9: rsp_done_o is 1 for exactly the one cycle after each completing access cycle. After a read (pwrite_o=0), rsp_rdata_o equals the prdata_i value sampled on the completing cycle.
- R10: A completing write does not change rsp_rdata_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Upstream command valid |
| req_ready_o | output | 1 | Controller can accept a command this cycle |
| req_write_i | input | 1 | Command is a write (1) or a read (0) |
| req_addr_i | input | ADDR_W | Command address |
| req_wdata_i | input | DATA_W | Command write data |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | DATA_W | Data returned by the last read |
| psel_o | output | 1 | APB select |
| penable_o | output | 1 | APB enable strobe |
| paddr_o | output | ADDR_W | APB address |
| pwrite_o | output | 1 | APB write flag |
| pwdata_o | output | DATA_W | APB write data |
| pready_i | input | 1 | Completer ready |
| prdata_i | input | DATA_W | Completer read data |

## Verification
The bench targets wait states and changes on the command port during a wait. A design that blinks the enable during a wait, or that lets new command fields leak onto the bus, gives a strobe gap or a moving address. A zero-wait transfer catches an enable held for a phantom second cycle. Back-to-back commands catch a controller that inserts an idle cycle or skips setup, and a reset taken in the middle of an access checks that select and enable drop at once. Read and write completions are mixed to expose read data that gets overwritten by writes, and a done pulse that arrives late or lasts too long.

// File: rtl/apb_xfer_pkg.sv
package apb_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ACCESS = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/apb_xfer_fsm.sv
module apb_xfer_fsm
  import apb_xfer_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic        pready_i,
  output xfer_state_e state_o,
  output logic        ready_o,
  output logic        take_o,
  output logic        complete_o
);
  xfer_state_e state_q, state_d;

  assign complete_o = (state_q == ST_ACCESS) && pready_i;
  assign ready_o    = (state_q == ST_IDLE) || complete_o;
  assign take_o     = ready_o && req_valid_i;
  assign state_o    = state_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_valid_i) state_d = ST_SETUP;
      ST_SETUP:  state_d = ST_ACCESS;
      ST_ACCESS: if (pready_i) state_d = req_valid_i ? ST_SETUP : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R3: setup always lasts a single cycle
  a_r3_setup_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SETUP) |=> (state_q == ST_ACCESS));

  // R6 / R7: exit of access follows the pending request
  a_r6_r7_complete_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete_o |=> (state_q == (($past(req_valid_i)) ? ST_SETUP : ST_IDLE)));
endmodule

// File: rtl/apb_xfer_regs.sv
module apb_xfer_regs #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              complete_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] prdata_i,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              pwrite_o,
  output logic [DATA_W-1:0] pwdata_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      paddr_o  <= '0;
      pwrite_o <= 1'b0;
      pwdata_o <= '0;
    end else if (take_i) begin
      paddr_o  <= req_addr_i;
      pwrite_o <= req_write_i;
      pwdata_o <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= complete_i;
      if (complete_i && !pwrite_o) rdata_o <= prdata_i;
    end
  end

  // R9: done only follows a completing cycle
  a_r9_done_after_complete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(complete_i));
endmodule

// File: rtl/apb_xfer_mgr.sv
module apb_xfer_mgr
  import apb_xfer_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              psel_o,
  output logic              penable_o,
  output logic [ADDR_W-1:0] paddr_o,
  output logic              pwrite_o,
  output logic [DATA_W-1:0] pwdata_o,
  input  logic              pready_i,
  input  logic [DATA_W-1:0] prdata_i
);
  xfer_state_e state;
  logic        take, complete;

  apb_xfer_fsm u_fsm (
    .clk_i,
    .rst_ni,
    .req_valid_i,
    .pready_i,
    .state_o    (state),
    .ready_o    (req_ready_o),
    .take_o     (take),
    .complete_o (complete)
  );

  apb_xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i,
    .rst_ni,
    .take_i      (take),
    .complete_i  (complete),
    .req_write_i,
    .req_addr_i,
    .req_wdata_i,
    .prdata_i,
    .paddr_o,
    .pwrite_o,
    .pwdata_o,
    .done_o      (rsp_done_o),
    .rdata_o     (rsp_rdata_o)
  );

  // Strobe is the bare state decode; nothing else drives it.
  assign psel_o    = (state != ST_IDLE);
  assign penable_o = (state == ST_ACCESS);

  a_r2_enable_needs_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    penable_o |-> psel_o);

  a_r2_enable_after_setup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(penable_o) |-> $past(psel_o));

  a_r4_wait_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (penable_o && !pready_i) |=> (penable_o && $stable(paddr_o) && $stable(pwrite_o)
                                  && $stable(pwdata_o)));

  a_r5_zero_wait_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(penable_o) && pready_i) |=> !penable_o);
endmodule

// File: tb/apb_xfer_mgr_tb_top.sv
`timescale 1ns/1ps
module apb_xfer_mgr_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0, req_write_i = 1'b0, pready_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0, prdata_i = '0;
  logic          req_ready_o, rsp_done_o, psel_o, penable_o, pwrite_o;
  logic [DW-1:0] rsp_rdata_o, pwdata_o;
  logic [AW-1:0] paddr_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  apb_xfer_mgr #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_i, .rst_ni, .req_valid_i, .req_ready_o, .req_write_i, .req_addr_i,
    .req_wdata_i, .rsp_done_o, .rsp_rdata_o, .psel_o, .penable_o, .paddr_o,
    .pwrite_o, .pwdata_o, .pready_i, .prdata_i
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, tag, act, exp);
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  task automatic t_reset();
    #1;
    eq("R1 psel in reset", psel_o, 0);
    eq("R1 penable in reset", penable_o, 0);
    eq("R1 done in reset", rsp_done_o, 0);
    eq("R1 ready in reset", req_ready_o, 1);
    step(); rst_ni = 1'b1;
    step();
    eq("R1 psel after release", psel_o, 0);
    eq("R1 ready after release", req_ready_o, 1);
  endtask

  task automatic t_zero_wait_write();
    pready_i = 1; req_valid_i = 1; req_write_i = 1;
    req_addr_i = 32'h1000_0040; req_wdata_i = 32'hCAFE_0001;
    #1 eq("R8 ready idle", req_ready_o, 1);
    step(); req_valid_i = 0;
    eq("R3 setup psel", psel_o, 1);
    eq("R3 setup penable", penable_o, 0);
    eq("R3 setup paddr", paddr_o, 32'h1000_0040);
    eq("R3 setup pwrite", pwrite_o, 1);
    eq("R3 setup pwdata", pwdata_o, 32'hCAFE_0001);
    step();
    eq("R5 access penable", penable_o, 1);
    eq("R8 ready on complete", req_ready_o, 1);
    step();
    eq("R5 penable drops", penable_o, 0);
    eq("R6 idle psel", psel_o, 0);
    eq("R9 done pulse", rsp_done_o, 1);
    step();
    eq("R9 done single", rsp_done_o, 0);
  endtask

  task automatic t_wait_read();
    pready_i = 0; req_valid_i = 1; req_write_i = 0;
    req_addr_i = 32'h2000_0008;
    step(); req_valid_i = 0;
    eq("R3 read setup penable", penable_o, 0);
    step();
    eq("R3 access after setup", penable_o, 1);
    for (int i = 0; i < 3; i++) begin
      req_addr_i = 32'hDEAD_0000 + i; req_wdata_i = 32'h5555_0000 + i;
      req_write_i = 1; req_valid_i = (i == 1);
      #1 eq("R8 ready low in wait", req_ready_o, 0);
      step();
      eq("R4 penable held", penable_o, 1);
      eq("R4 paddr held", paddr_o, 32'h2000_0008);
      eq("R4 pwrite held", pwrite_o, 0);
    end
    req_valid_i = 0; pready_i = 1; prdata_i = 32'h1234_ABCD;
    step();
    eq("R6 idle after read", psel_o, 0);
    eq("R9 read done", rsp_done_o, 1);
    eq("R9 read data", rsp_rdata_o, 32'h1234_ABCD);
  endtask

  task automatic t_back_to_back();
    pready_i = 1; req_valid_i = 1; req_write_i = 1;
    req_addr_i = 32'h3000_0000; req_wdata_i = 32'h0000_00AA;
    step();
    req_write_i = 0; req_addr_i = 32'h3000_0004;
    step();
    eq("R7 first access paddr", paddr_o, 32'h3000_0000);
    eq("R8 ready at complete", req_ready_o, 1);
    prdata_i = 32'h0BAD_F00D;
    step(); req_valid_i = 0;
    eq("R7 psel stays", psel_o, 1);
    eq("R7 new setup penable", penable_o, 0);
    eq("R7 new paddr", paddr_o, 32'h3000_0004);
    eq("R7 done of first", rsp_done_o, 1);
    step();
    eq("R7 second access", penable_o, 1);
    step();
    eq("R9 second done", rsp_done_o, 1);
    eq("R9 second rdata", rsp_rdata_o, 32'h0BAD_F00D);
  endtask

  task automatic t_write_keeps_rdata();
    pready_i = 1; req_valid_i = 1; req_write_i = 1;
    req_addr_i = 32'h4000_0000; prdata_i = 32'hFFFF_0000;
    step(); req_valid_i = 0;
    step(); step();
    eq("R10 write done", rsp_done_o, 1);
    eq("R10 rdata kept", rsp_rdata_o, 32'h0BAD_F00D);
  endtask

  task automatic t_reset_mid();
    pready_i = 0; req_valid_i = 1; req_write_i = 0; req_addr_i = 32'h5000_0000;
    step(); req_valid_i = 0;
    step();
    eq("R4 in access before reset", penable_o, 1);
    rst_ni = 0; #1;
    eq("R1 psel reset mid", psel_o, 0);
    eq("R1 penable reset mid", penable_o, 0);
    eq("R1 ready reset mid", req_ready_o, 1);
    step(); rst_ni = 1; step();
    eq("R2 no strobe after reset", penable_o, 0);
  endtask

  initial begin
    t_reset();
    t_zero_wait_write();
    t_wait_read();
    t_back_to_back();
    t_write_keeps_rdata();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule